// File: doc/BRIEF.md
# Bus-Power and Pull-Up Pin Controller

This block sits in a USB-to-storage bridge and drives the pins that report the power state and that switch the host-side pull-ups on the ATA cable. It decides when the device may draw high current from the bus. That permission depends on the USB configuration value, a bus-powered sense input, a drive-power-valid input and the suspend state. It also sets the pull-up enable from ATA bus activity, and it picks the max-power and self-powered values that the configuration descriptor reports.

The high-current permission is registered. On entry to suspend it is saved and forced inactive. On resume the saved value comes back for one cycle, and after that the live conditions take over again. Two bits of a nonvolatile configuration byte select the optional tri-state behaviour of the two pin drivers. A build parameter selects whether a power-sense pin exists. Without one, the descriptor values come from stored configuration inputs.

Top module: `bus_power_ctrl`

## Requirements
- R1: `pu_en` equals the value of `ata_bus_active` one clock earlier, so it is 1 while the ATA bus is active and 0 while it is idle.
- R2: `pu_oe` is 0 (high impedance) one clock after `nv_cfg_byte[4]` = 1 and `ata_vbus_en` = 0 are seen together, and is 1 in every other case.
- R3: `hi_cur_n` is 0 (active) only when, one clock earlier, `usb_cfg_val` was nonzero, `drv_pwr_valid` was 1 and the synchronized sense input was 1. Otherwise it is 1.
- R4: While `suspend_in` is 1, `hi_cur_n` is 1 from the clock after it is first seen.
- R5: On the first clock after `suspend_in` falls, `hi_cur_n` takes back the value it had just before the suspend. From the next clock it follows the R3 conditions again.
- R6: When `nv_cfg_byte[1]` = 1, `hi_cur_oe` is 1 only one clock after `drv_pwr_valid` = 1. When that bit is 0, `hi_cur_oe` is 1.
- R7: With the sense pin present, a synchronized sense value of 1 gives `desc_max_power` = 250 and `desc_self_pwr` = 0, and a value of 0 gives `desc_max_power` = 1 and `desc_self_pwr` = 1.
- R8: `vbus_sense_raw` passes through a two-flop synchronizer. A change reaches the descriptor outputs on the third rising edge after it is applied, and not earlier.
- R9: With `HAS_SENSE_PIN` = 0, the descriptor outputs copy `stored_max_power` and `stored_self_pwr`, and R3 treats the sense as always 1.
- R10: While `rst_n` is 0, every output takes its inactive value from the next edge onward: `hi_cur_n` = 1, `hi_cur_oe` = 0, `pu_en` = 0, `pu_oe` = 0, descriptor outputs 0. The saved suspend value is also cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| usb_cfg_val | input | CFG_W | Current USB configuration value (0 = unconfigured) |
| suspend_in | input | 1 | Low-power state request |
| vbus_sense_raw | input | 1 | Asynchronous bus-powered sense input |
| drv_pwr_valid | input | 1 | Drive power valid |
| ata_bus_active | input | 1 | ATA bus activity |
| ata_vbus_en | input | 1 | ATA-side enable from bus power |
| nv_cfg_byte | input | 8 | Configuration byte: bit 4 ATA enable feature, bit 1 drive-power-valid enable |
| stored_max_power | input | 8 | Stored max-power value used without a sense pin |
| stored_self_pwr | input | 1 | Stored self-powered attribute used without a sense pin |
| hi_cur_n | output | 1 | High-current permission, active low |
| hi_cur_oe | output | 1 | Output enable for `hi_cur_n` |
| pu_en | output | 1 | Pull-up enable |
| pu_oe | output | 1 | Output enable for `pu_en` |
| desc_max_power | output | 8 | Max-power descriptor value |
| desc_self_pwr | output | 1 | Self-powered descriptor attribute bit |

## Verification
The assertions assume that `suspend_in`, `drv_pwr_valid`, `usb_cfg_val` and the configuration byte are synchronous to `clk`. They also assume that only `vbus_sense_raw` may change without regard to the clock. For that reason no property ties the sense pin to `hi_cur_n` through the synchronizer. The stimulus changes every input on the falling edge and holds it for several cycles. The suspend sequence changes `drv_pwr_valid` while suspended, so the one-cycle restore can be told apart from the live value.

// File: rtl/bpc_pkg.sv
// Package: shared constants and types for the bus-power controller.
// Assumes the configuration byte layout is fixed by the loader upstream.
package bpc_pkg;
    localparam int ATA_EN_BIT  = 4;        // ATA-side tri-state feature
    localparam int DPV_EN_BIT  = 1;        // drive-power-valid gating of high-current pin
    localparam logic [7:0] MAXPWR_BUS  = 8'd250;  // 500 mA in 2 mA units
    localparam logic [7:0] MAXPWR_SELF = 8'd1;    // 2 mA

    typedef struct packed {
        logic [7:0] max_power;
        logic       self_pwr;
    } desc_t;
endpackage

// File: rtl/bpc_sense_sync.sv
// Module: multi-flop synchronizer for the asynchronous power-sense input.
// Assumes STAGES >= 2; resets to 0 (self-powered reading).
module bpc_sense_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bpc_hicur_ctrl.sv
// Module: high-current permission with suspend save/restore and optional
// tri-state gating by drive power valid. Assumes synchronous inputs.
module bpc_hicur_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic configured,
    input  logic sense_ok,
    input  logic drv_valid,
    input  logic dpv_gate_en,
    input  logic suspend,
    output logic hi_cur_n,
    output logic hi_cur_oe
);
    logic grant;
    logic active_q;
    logic saved_q;
    logic susp_q;
    logic oe_q;

    // Live permission: every power source must agree.
    always_comb grant = configured & sense_ok & drv_valid;

    // Remember last cycle's suspend to find entry and exit.
    always_ff @(posedge clk) begin
        if (!rst_n) susp_q <= 1'b0;
        else        susp_q <= suspend;
    end

    // Capture the permission at suspend entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                   saved_q <= 1'b0;
        else if (suspend && !susp_q)  saved_q <= active_q;
    end

    // Permission register: off in suspend, restored on exit, else live.
    always_ff @(posedge clk) begin
        if (!rst_n)       active_q <= 1'b0;
        else if (suspend) active_q <= 1'b0;
        else if (susp_q)  active_q <= saved_q;
        else              active_q <= grant;
    end

    // Pin driver enable: gated by drive power valid when the feature is on.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= !dpv_gate_en || drv_valid;
    end

    assign hi_cur_n  = ~active_q;
    assign hi_cur_oe = oe_q;
endmodule

// File: rtl/bpc_pullup_ctrl.sv
// Module: pull-up enable for the ATA cable and its tri-state control.
// Assumes activity and enable inputs are synchronous.
module bpc_pullup_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_active,
    input  logic vbus_en,
    input  logic tristate_feature,
    output logic pu_en,
    output logic pu_oe
);
    // Register the pull-up level and its driver enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pu_en <= 1'b0;
            pu_oe <= 1'b0;
        end else begin
            pu_en <= bus_active;
            pu_oe <= !(tristate_feature && !vbus_en);
        end
    end
endmodule

// File: rtl/bpc_desc_sel.sv
// Module: selects descriptor power fields from the sense pin or stored values.
// Assumes sense_ok is already synchronized.
module bpc_desc_sel
    import bpc_pkg::*;
#(
    parameter bit HAS_SENSE_PIN = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sense_ok,
    input  logic [7:0] stored_max,
    input  logic       stored_self,
    output desc_t      desc
);
    desc_t next_desc;

    generate
        if (HAS_SENSE_PIN) begin : g_pin
            // Pick bus- or self-powered values from the sense level.
            always_comb begin
                next_desc.max_power = sense_ok ? MAXPWR_BUS : MAXPWR_SELF;
                next_desc.self_pwr  = !sense_ok;
            end
        end else begin : g_stored
            // Pass the stored values through.
            always_comb begin
                next_desc.max_power = stored_max;
                next_desc.self_pwr  = stored_self;
            end
        end
    endgenerate

    // Register the chosen fields.
    always_ff @(posedge clk) begin
        if (!rst_n) desc <= '0;
        else        desc <= next_desc;
    end
endmodule

// File: rtl/bus_power_ctrl.sv
// Module: top of the bus-power and pull-up pin controller.
// Assumes all inputs except vbus_sense_raw are synchronous to clk.
module bus_power_ctrl
    import bpc_pkg::*;
#(
    parameter bit HAS_SENSE_PIN = 1'b1,
    parameter int CFG_W         = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] usb_cfg_val,
    input  logic             suspend_in,
    input  logic             vbus_sense_raw,
    input  logic             drv_pwr_valid,
    input  logic             ata_bus_active,
    input  logic             ata_vbus_en,
    input  logic [7:0]       nv_cfg_byte,
    input  logic [7:0]       stored_max_power,
    input  logic             stored_self_pwr,
    output logic             hi_cur_n,
    output logic             hi_cur_oe,
    output logic             pu_en,
    output logic             pu_oe,
    output logic [7:0]       desc_max_power,
    output logic             desc_self_pwr
);
    logic  sense_ok;
    logic  configured;
    desc_t desc;

    assign configured = |usb_cfg_val;

    generate
        if (HAS_SENSE_PIN) begin : g_sense
            bpc_sense_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .d_async (vbus_sense_raw),
                .q_sync  (sense_ok)
            );
        end else begin : g_nosense
            assign sense_ok = 1'b1;
        end
    endgenerate

    bpc_hicur_ctrl u_hicur (
        .clk         (clk),
        .rst_n       (rst_n),
        .configured  (configured),
        .sense_ok    (sense_ok),
        .drv_valid   (drv_pwr_valid),
        .dpv_gate_en (nv_cfg_byte[DPV_EN_BIT]),
        .suspend     (suspend_in),
        .hi_cur_n    (hi_cur_n),
        .hi_cur_oe   (hi_cur_oe)
    );

    bpc_pullup_ctrl u_pullup (
        .clk              (clk),
        .rst_n            (rst_n),
        .bus_active       (ata_bus_active),
        .vbus_en          (ata_vbus_en),
        .tristate_feature (nv_cfg_byte[ATA_EN_BIT]),
        .pu_en            (pu_en),
        .pu_oe            (pu_oe)
    );

    bpc_desc_sel #(.HAS_SENSE_PIN(HAS_SENSE_PIN)) u_desc (
        .clk         (clk),
        .rst_n       (rst_n),
        .sense_ok    (sense_ok),
        .stored_max  (stored_max_power),
        .stored_self (stored_self_pwr),
        .desc        (desc)
    );

    assign desc_max_power = desc.max_power;
    assign desc_self_pwr  = desc.self_pwr;
endmodule

// File: rtl/bus_power_ctrl_chk.sv
// Checker: temporal properties of bus_power_ctrl, bound to every instance.
// Assumes synchronous inputs apart from the raw sense pin.
module bus_power_ctrl_chk #(
    parameter bit HAS_SENSE_PIN = 1'b1,
    parameter int CFG_W         = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] usb_cfg_val,
    input logic             suspend_in,
    input logic             drv_pwr_valid,
    input logic             ata_bus_active,
    input logic             ata_vbus_en,
    input logic [7:0]       nv_cfg_byte,
    input logic             hi_cur_n,
    input logic             hi_cur_oe,
    input logic             pu_en,
    input logic             pu_oe,
    input logic [7:0]       desc_max_power,
    input logic             desc_self_pwr
);
    logic susp_prev;

    // Track the previous suspend level seen by the checker.
    always_ff @(posedge clk) begin
        if (!rst_n) susp_prev <= 1'b0;
        else        susp_prev <= suspend_in;
    end

    p_pu_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pu_en == $past(ata_bus_active)));

    p_pu_tristate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_cfg_byte[4] && !ata_vbus_en) |=> !pu_oe);

    p_pu_driven_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!nv_cfg_byte[4] || ata_vbus_en) |=> pu_oe);

    p_hicur_needs_power_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspend_in && !susp_prev && !((|usb_cfg_val) && drv_pwr_valid)) |=> hi_cur_n);

    p_suspend_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_in |=> hi_cur_n);

    p_oe_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_cfg_byte[1] && !drv_pwr_valid) |=> !hi_cur_oe);

    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> (hi_cur_n && !hi_cur_oe && !pu_en && !pu_oe));

    generate
        if (HAS_SENSE_PIN) begin : g_desc
            p_desc_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (desc_self_pwr ? (desc_max_power == 8'd1)
                                                : (desc_max_power == 8'd250)));
        end
    endgenerate
endmodule

bind bus_power_ctrl bus_power_ctrl_chk #(
    .HAS_SENSE_PIN (HAS_SENSE_PIN),
    .CFG_W         (CFG_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .usb_cfg_val    (usb_cfg_val),
    .suspend_in     (suspend_in),
    .drv_pwr_valid  (drv_pwr_valid),
    .ata_bus_active (ata_bus_active),
    .ata_vbus_en    (ata_vbus_en),
    .nv_cfg_byte    (nv_cfg_byte),
    .hi_cur_n       (hi_cur_n),
    .hi_cur_oe      (hi_cur_oe),
    .pu_en          (pu_en),
    .pu_oe          (pu_oe),
    .desc_max_power (desc_max_power),
    .desc_self_pwr  (desc_self_pwr)
);

// File: tb/bus_power_ctrl_bench.sv
// Bench: vector table walk plus directed reset, suspend and synchronizer tests.
module bus_power_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] usb_cfg_val = '0;
    logic       suspend_in = 1'b0;
    logic       vbus_sense_raw = 1'b0;
    logic       drv_pwr_valid = 1'b0;
    logic       ata_bus_active = 1'b0;
    logic       ata_vbus_en = 1'b0;
    logic [7:0] nv_cfg_byte = '0;
    logic [7:0] stored_max_power = 8'd100;
    logic       stored_self_pwr = 1'b1;

    logic       hi_cur_n, hi_cur_oe, pu_en, pu_oe, desc_self_pwr;
    logic [7:0] desc_max_power;
    logic       np_hi_cur_n, np_hi_cur_oe, np_pu_en, np_pu_oe, np_self;
    logic [7:0] np_max;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    bus_power_ctrl u_bus_power_ctrl (
        .clk(clk), .rst_n(rst_n), .usb_cfg_val(usb_cfg_val), .suspend_in(suspend_in),
        .vbus_sense_raw(vbus_sense_raw), .drv_pwr_valid(drv_pwr_valid),
        .ata_bus_active(ata_bus_active), .ata_vbus_en(ata_vbus_en),
        .nv_cfg_byte(nv_cfg_byte), .stored_max_power(stored_max_power),
        .stored_self_pwr(stored_self_pwr), .hi_cur_n(hi_cur_n), .hi_cur_oe(hi_cur_oe),
        .pu_en(pu_en), .pu_oe(pu_oe), .desc_max_power(desc_max_power),
        .desc_self_pwr(desc_self_pwr)
    );

    bus_power_ctrl #(.HAS_SENSE_PIN(1'b0)) u_nopin (
        .clk(clk), .rst_n(rst_n), .usb_cfg_val(usb_cfg_val), .suspend_in(suspend_in),
        .vbus_sense_raw(vbus_sense_raw), .drv_pwr_valid(drv_pwr_valid),
        .ata_bus_active(ata_bus_active), .ata_vbus_en(ata_vbus_en),
        .nv_cfg_byte(nv_cfg_byte), .stored_max_power(stored_max_power),
        .stored_self_pwr(stored_self_pwr), .hi_cur_n(np_hi_cur_n), .hi_cur_oe(np_hi_cur_oe),
        .pu_en(np_pu_en), .pu_oe(np_pu_oe), .desc_max_power(np_max),
        .desc_self_pwr(np_self)
    );

    // Vector: {cfg, sense, dpv, dpv_en, ata_act, vbus_en, ata_en, e_hcn, e_hoe, e_pen, e_poe}
    localparam int NVEC = 8;
    localparam logic [10:0] VEC [NVEC] = '{
        11'b1110010_0101,
        11'b0110110_1111,
        11'b1010100_1111,
        11'b1100001_1100,
        11'b1101111_1011,
        11'b1111011_0101,
        11'b0001101_1010,
        11'b1110101_0110
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #4000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        // R10: reset with inputs that would otherwise activate outputs
        usb_cfg_val = 8'd1; vbus_sense_raw = 1'b1; drv_pwr_valid = 1'b1;
        ata_bus_active = 1'b1; ata_vbus_en = 1'b1;
        settle(3);
        check("R10", "hi_cur_n", hi_cur_n, 1);
        check("R10", "hi_cur_oe", hi_cur_oe, 0);
        check("R10", "pu_en", pu_en, 0);
        check("R10", "pu_oe", pu_oe, 0);
        check("R10", "desc_max_power", desc_max_power, 0);
        check("R10", "desc_self_pwr", desc_self_pwr, 0);
        check("R10", "nopin desc_max_power", np_max, 0);
        rst_n = 1'b1;

        // Table walk: R1, R2, R3, R6, R7, R9
        for (int i = 0; i < NVEC; i++) begin
            logic [10:0] v;
            v = VEC[i];
            usb_cfg_val    = {7'd0, v[10]};
            vbus_sense_raw = v[9];
            drv_pwr_valid  = v[8];
            nv_cfg_byte    = {3'b000, v[4], 2'b00, v[7], 1'b0};
            ata_bus_active = v[6];
            ata_vbus_en    = v[5];
            settle(4);
            check("R3", "hi_cur_n", hi_cur_n, v[3]);
            check("R6", "hi_cur_oe", hi_cur_oe, v[2]);
            check("R1", "pu_en", pu_en, v[1]);
            check("R2", "pu_oe", pu_oe, v[0]);
            check("R7", "desc_max_power", desc_max_power, v[9] ? 250 : 1);
            check("R7", "desc_self_pwr", desc_self_pwr, v[9] ? 0 : 1);
            check("R9", "nopin hi_cur_n", np_hi_cur_n, (v[10] && v[8]) ? 0 : 1);
            check("R9", "nopin desc_max_power", np_max, 100);
            check("R9", "nopin desc_self_pwr", np_self, 1);
        end

        // R8: synchronizer latency on the descriptor
        vbus_sense_raw = 1'b1; settle(4);
        vbus_sense_raw = 1'b0;
        settle(2);
        check("R8", "desc after 2 edges", desc_max_power, 250);
        settle(1);
        check("R8", "desc after 3 edges", desc_max_power, 1);
        check("R8", "self after 3 edges", desc_self_pwr, 1);

        // R4/R5: suspend save and restore
        usb_cfg_val = 8'd1; vbus_sense_raw = 1'b1; drv_pwr_valid = 1'b1;
        nv_cfg_byte = 8'h00;
        settle(4);
        check("R3", "hi_cur_n before suspend", hi_cur_n, 0);
        suspend_in = 1'b1;
        settle(1);
        check("R4", "hi_cur_n on suspend", hi_cur_n, 1);
        drv_pwr_valid = 1'b0;
        settle(2);
        check("R4", "hi_cur_n held in suspend", hi_cur_n, 1);
        suspend_in = 1'b0;
        settle(1);
        check("R5", "hi_cur_n restored", hi_cur_n, 0);
        settle(1);
        check("R5", "hi_cur_n live after restore", hi_cur_n, 1);

        // R1: idle after active
        ata_bus_active = 1'b1; settle(1);
        ata_bus_active = 1'b0; settle(1);
        check("R1", "pu_en idle", pu_en, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule